// File: doc/BRIEF.md
# Phrase Record/Playback Sequencer

This block runs the recording and playback of a 1-bit-per-sample coded voice stream held in an external byte-wide static RAM. Pins control it directly. A mode level picks what a start request means. When the mode is high the start request records, and when it is low the start request plays back. Stop requests end a recording or hold a playback in place. Each recorded phrase gets a slot in a small directory that keeps its first bit address and its end bit address. A later playback of that slot preloads the address counter and a stop-address register from the directory.

The address counter counts single coded bits. Its upper bits form the SRAM byte address and its low three bits pick the bit inside that byte. A divider derived from the system clock produces one sample strobe per coded bit at one of four rates. All memory traffic happens on that strobe. The SRAM read data is taken as the current content of the presented byte address, with no wait. Recording writes a whole byte after replacing only the addressed bit, so phrases that share a byte keep each other's bits.

The memory limit follows a size input. With it low, the limit is a quarter of the full range, like four small devices. With it high, the limit is the full counter span, like four devices of four times that size. A recording that reaches the limit stops by itself.

Top module: `phrase_seq`

## Requirements
- R1: After reset no request is in progress. The write strobe, the playback valid and done outputs, both busy flags and the pause flag are 0, and the recorded-phrase count is 0.
- R2: With the mode input low, a rising edge on the start input (low in the previous clock, high in this one) begins playback of the selected slot only if that slot holds a recorded phrase. A start edge that selects an empty slot leaves the block idle and changes nothing.
- R3: Playback emits the phrase's bits in recording order, one per strobe, on the bit output with a one-clock valid pulse. Within a byte, bit position n holds bit address (byte address*8 + n). After the last bit, the done output pulses for exactly one clock and the block returns to idle.
- R4: A rising edge on the stop input during playback holds it. While held, no bit is emitted and the address does not move. A later start rising edge resumes with the next unplayed bit.
- R5: With the mode input high, a start rising edge begins recording at the next free bit address. That address is 0 for the first phrase and the end address of the previous phrase after that. Each strobe raises the write strobe for one clock with byte address = bit address >> 3, and the data carries the input bit at position bit address & 7.
- R6: A stop rising edge during recording ends the phrase without storing a further bit. It saves the phrase's end address and increments the phrase count.
- R7: Recording ends on its own right after the bit at address MAX-1 is written. MAX is 2^(ADDR_W-2) bits when the size input is 0 and 2^ADDR_W bits when it is 1.
- R8: A recording start edge is ignored when all PHRASES slots are used or when the next free address is not below MAX.
- R9: The strobe period is BASE_DIV*(rate+1) clocks for rate code 0..3. The codes stand for 32, 16, about 11 and 8 kbit/s when BASE_DIV is the clock frequency divided by 32000. The first strobe comes exactly one period after the accepted start edge.
- R10: A phrase stopped before any strobe has zero length. Playing it raises done with no bit emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rec | input | 1 | 1: start records, 0: start plays |
| start_in | input | 1 | Start/resume request, edge detected |
| stop_in | input | 1 | Stop/pause request, edge detected |
| phrase_sel | input | $clog2(PHRASES) | Slot chosen for playback |
| rate_sel | input | 2 | Sample rate code |
| mem_large | input | 1 | Memory size select |
| rec_bit | input | 1 | Coded bit to record |
| sram_rdata | input | 8 | SRAM content at sram_addr |
| sram_addr | output | ADDR_W-3 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write strobe, one clock |
| play_bit | output | 1 | Played coded bit |
| play_vld | output | 1 | play_bit valid, one clock |
| play_done | output | 1 | Phrase playback finished, one clock |
| rec_busy | output | 1 | Recording in progress |
| play_busy | output | 1 | Playback in progress or held |
| paused | output | 1 | Playback held |
| phrase_cnt | output | $clog2(PHRASES)+1 | Number of recorded phrases |

## Verification
Every slot is filled with its own arithmetic bit pattern. The patterns differ in slot number and position, so a swapped slot, a shifted address or a wrong bit position inside a byte shows up as a data mismatch. The first phrases start off byte boundaries and use all four rates. The bench times the spacing between strobes, which separates the four rate divisors and the first-strobe latency. A long phrase fills the small memory so it stops on overflow, after which further recording is refused. The size is then switched to large and the directory is filled to its last slot, ending with a zero-length phrase and a refused seventeenth start. Every slot is played back, two of them with a hold and resume in the middle, and a start on an empty slot is tried.

// File: rtl/phrase_seq.sv
module phrase_seq #(
  parameter int ADDR_W   = 20,
  parameter int BASE_DIV = 3125,
  parameter int PHRASES  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_rec,
  input  logic                        start_in,
  input  logic                        stop_in,
  input  logic [$clog2(PHRASES)-1:0]  phrase_sel,
  input  logic [1:0]                  rate_sel,
  input  logic                        mem_large,
  input  logic                        rec_bit,
  input  logic [7:0]                  sram_rdata,
  output logic [ADDR_W-4:0]           sram_addr,
  output logic [7:0]                  sram_wdata,
  output logic                        sram_we,
  output logic                        play_bit,
  output logic                        play_vld,
  output logic                        play_done,
  output logic                        rec_busy,
  output logic                        play_busy,
  output logic                        paused,
  output logic [$clog2(PHRASES):0]    phrase_cnt
);
  localparam int CW = ADDR_W + 1;
  localparam int IW = $clog2(PHRASES);
  localparam int DW = $clog2(BASE_DIV * 4 + 1);

  typedef enum logic [1:0] {S_IDLE, S_REC, S_PLAY, S_HOLD} st_t;

  st_t           state;
  logic [CW-1:0] cnt, stop_reg, free_ptr, max_bits, end_val;
  logic [DW-1:0] div, period;
  logic          start_q, stop_q, start_rise, stop_rise;
  logic          active, tick, sel_ok, can_rec, last_bit, rec_go, rec_end;
  logic [CW-1:0] beg_tab [PHRASES];
  logic [CW-1:0] fin_tab [PHRASES];

  assign start_rise = start_in & ~start_q;
  assign stop_rise  = stop_in & ~stop_q;
  assign max_bits   = mem_large ? (CW'(1) << ADDR_W) : (CW'(1) << (ADDR_W - 2));
  assign period     = DW'(BASE_DIV) * {{(DW-2){1'b0}}, rate_sel} + DW'(BASE_DIV);
  assign active     = (state == S_REC) || (state == S_PLAY);
  assign tick       = active && (div >= period - DW'(1));
  assign sel_ok     = {1'b0, phrase_sel} < phrase_cnt;
  assign can_rec    = (phrase_cnt < (IW+1)'(PHRASES)) && (free_ptr < max_bits);
  assign last_bit   = (cnt + CW'(1)) >= max_bits;
  assign rec_go     = (state == S_IDLE) && start_rise && mode_rec && can_rec;
  assign rec_end    = (state == S_REC) && (stop_rise || (tick && last_bit));
  assign end_val    = stop_rise ? cnt : cnt + CW'(1);

  assign sram_addr = cnt[ADDR_W-1:3];
  assign sram_we   = (state == S_REC) && tick && !stop_rise;
  assign rec_busy  = (state == S_REC);
  assign play_busy = (state == S_PLAY) || (state == S_HOLD);
  assign paused    = (state == S_HOLD);

  always_comb begin
    sram_wdata = sram_rdata;
    sram_wdata[cnt[2:0]] = rec_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      stop_reg   <= '0;
      free_ptr   <= '0;
      phrase_cnt <= '0;
      div        <= '0;
      start_q    <= 1'b0;
      stop_q     <= 1'b0;
      play_bit   <= 1'b0;
      play_vld   <= 1'b0;
      play_done  <= 1'b0;
    end else begin
      start_q   <= start_in;
      stop_q    <= stop_in;
      play_vld  <= 1'b0;
      play_done <= 1'b0;
      div       <= (tick || !active) ? '0 : div + DW'(1);
      case (state)
        S_IDLE: begin
          if (rec_go) begin
            cnt   <= free_ptr;
            state <= S_REC;
          end else if (start_rise && !mode_rec && sel_ok) begin
            cnt      <= beg_tab[phrase_sel];
            stop_reg <= fin_tab[phrase_sel];
            state    <= S_PLAY;
          end
        end
        S_REC: begin
          if (tick && !stop_rise) cnt <= cnt + CW'(1);
          if (rec_end) begin
            free_ptr   <= end_val;
            phrase_cnt <= phrase_cnt + 1'b1;
            state      <= S_IDLE;
          end
        end
        S_PLAY: begin
          if (cnt == stop_reg) begin
            play_done <= 1'b1;
            state     <= S_IDLE;
          end else if (stop_rise) begin
            state <= S_HOLD;
          end else if (tick) begin
            play_bit <= sram_rdata[cnt[2:0]];
            play_vld <= 1'b1;
            cnt      <= cnt + CW'(1);
          end
        end
        default: begin
          if (start_rise) state <= S_PLAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rec_go)  beg_tab[phrase_cnt[IW-1:0]] <= free_ptr;
    if (rec_end) fin_tab[phrase_cnt[IW-1:0]] <= end_val;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_done |=> !play_done);

  // R7
  write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (cnt < max_bits));

  // R5
  rec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REC && $past(sram_we)) |-> (cnt == $past(cnt) + CW'(1)));

  // R4
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && $past(state == S_HOLD)) |-> ($stable(cnt) && !play_vld));

  // R8
  slot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phrase_cnt <= (IW+1)'(PHRASES));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_busy) |-> (phrase_cnt == $past(phrase_cnt) + 1'b1));
endmodule

// File: tb/phrase_seq_tb_top.sv
`timescale 1ns/1ps
module phrase_seq_tb_top;
  localparam int ADDR_W = 8;
  localparam int BASE_DIV = 2;
  localparam int PHRASES = 16;
  localparam int SMALL_MAX = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_rec = 1'b0, start_in = 1'b0, stop_in = 1'b0, mem_large = 1'b0, rec_bit = 1'b0;
  logic [3:0] phrase_sel = '0;
  logic [1:0] rate_sel = '0;
  logic [7:0] sram_rdata, sram_wdata;
  logic [ADDR_W-4:0] sram_addr;
  logic sram_we, play_bit, play_vld, play_done, rec_busy, play_busy, paused;
  logic [4:0] phrase_cnt;
  logic [7:0] mem [1 << (ADDR_W-3)];

  int checks = 0, errors = 0, free_bits = 0;
  int ph_start [PHRASES];
  int ph_len [PHRASES];

  always #5 clk = ~clk;

  phrase_seq #(.ADDR_W(ADDR_W), .BASE_DIV(BASE_DIV), .PHRASES(PHRASES)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_rec(mode_rec), .start_in(start_in), .stop_in(stop_in),
    .phrase_sel(phrase_sel), .rate_sel(rate_sel), .mem_large(mem_large), .rec_bit(rec_bit),
    .sram_rdata(sram_rdata), .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .play_bit(play_bit), .play_vld(play_vld), .play_done(play_done), .rec_busy(rec_busy),
    .play_busy(play_busy), .paused(paused), .phrase_cnt(phrase_cnt));

  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (sram_we) mem[sram_addr] <= sram_wdata;

  function automatic int pbit(int p, int k);
    return ((k * (p + 3)) ^ (k >> 2) ^ p) & 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_in = 1'b1;
    @(negedge clk) start_in = 1'b0;
  endtask

  task automatic rec_run(int p, int len, int rate, bit ovf, int max_b);
    int k = 0, cyc = 1, last = 0, guard = 0, st = free_bits;
    int per = BASE_DIV * (rate + 1);
    mode_rec = 1'b1; rate_sel = 2'(rate);
    pulse_start();
    chk(rec_busy == 1'b1, "R5 record start accepted", rec_busy, 1);
    forever begin
      rec_bit = pbit(p, k)[0];
      if (sram_we) begin
        chk(int'(sram_addr) == (st + k) >> 3, "R5 byte address", sram_addr, (st + k) >> 3);
        chk(sram_wdata[(st + k) & 7] == pbit(p, k)[0], "R5 data bit", sram_wdata[(st + k) & 7], pbit(p, k));
        if (k == 0) chk(cyc == per, "R9 first strobe latency", cyc, per);
        else chk(cyc - last == per, "R9 strobe period", cyc - last, per);
        last = cyc;
        k++;
      end
      if (!ovf && k == len) break;
      if (ovf && !rec_busy) break;
      guard++;
      if (guard > 5000) break;
      @(negedge clk); cyc++;
    end
    if (!ovf) begin
      @(negedge clk) stop_in = 1'b1;
      @(negedge clk) stop_in = 1'b0;
      chk(k == len, "R6 stored bit count", k, len);
    end else begin
      chk(k == max_b - st, "R7 overflow bit count", k, max_b - st);
    end
    chk(rec_busy == 1'b0, "R6 recording ended", rec_busy, 0);
    chk(int'(phrase_cnt) == p + 1, "R6 phrase count", phrase_cnt, p + 1);
    ph_start[p] = st; ph_len[p] = k; free_bits = st + k;
  endtask

  task automatic ignored_start(bit m, int sel, string req);
    int cnt0 = phrase_cnt;
    bit wrote = 0, busy = 0;
    mode_rec = m; phrase_sel = 4'(sel);
    pulse_start();
    repeat (20) @(negedge clk) begin
      if (sram_we) wrote = 1;
      if (rec_busy || play_busy) busy = 1;
    end
    chk(!busy, req, busy, 0);
    chk(!wrote, req, wrote, 0);
    chk(int'(phrase_cnt) == cnt0, req, phrase_cnt, cnt0);
  endtask

  task automatic play_run(int p, int rate, int pause_at);
    int k = 0, guard = 0;
    bit got = 0, vld_in_hold = 0;
    mode_rec = 1'b0; rate_sel = 2'(rate); phrase_sel = 4'(p);
    pulse_start();
    chk(play_busy == 1'b1 || play_done == 1'b1, "R2 playback start", play_busy, 1);
    forever begin
      if (play_vld) begin
        chk(play_bit == pbit(p, k)[0], "R3 played bit", play_bit, pbit(p, k));
        k++;
        if (k == pause_at) begin
          @(negedge clk) stop_in = 1'b1;
          @(negedge clk) stop_in = 1'b0;
          chk(paused == 1'b1, "R4 hold entered", paused, 1);
          repeat (30) @(negedge clk) if (play_vld) vld_in_hold = 1;
          chk(!vld_in_hold, "R4 no bits while held", vld_in_hold, 0);
          pulse_start();
          chk(paused == 1'b0 && play_busy == 1'b1, "R4 resumed", paused, 0);
        end
      end
      if (play_done) begin got = 1; break; end
      guard++;
      if (guard > 5000) break;
      @(negedge clk);
    end
    chk(got, "R3 done raised", got, 1);
    if (ph_len[p] == 0) chk(k == 0, "R10 zero-length playback", k, 0);
    else chk(k == ph_len[p], "R3 played bit count", k, ph_len[p]);
    @(negedge clk);
    chk(play_done == 1'b0, "R3 done one clock", play_done, 0);
    chk(play_busy == 1'b0, "R3 back to idle", play_busy, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << (ADDR_W-3)); i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(sram_we == 1'b0 && play_vld == 1'b0 && play_done == 1'b0, "R1 strobes idle", sram_we, 0);
    chk(rec_busy == 1'b0 && play_busy == 1'b0 && paused == 1'b0, "R1 flags idle", rec_busy, 0);
    chk(phrase_cnt == 5'd0, "R1 phrase count", phrase_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rec_busy == 1'b0 && play_busy == 1'b0, "R1 idle after release", play_busy, 0);

    ignored_start(1'b0, 0, "R2 empty slot ignored");
    mem_large = 1'b0;
    rec_run(0, 20, 0, 1'b0, SMALL_MAX);
    rec_run(1, 13, 1, 1'b0, SMALL_MAX);
    rec_run(2, 9, 2, 1'b0, SMALL_MAX);
    rec_run(3, 0, 3, 1'b1, SMALL_MAX);
    ignored_start(1'b1, 0, "R8 full memory ignored");
    ignored_start(1'b0, 5, "R2 empty slot ignored");

    mem_large = 1'b1;
    for (int p = 4; p < 15; p++) rec_run(p, 3, p % 4, 1'b0, 1 << ADDR_W);
    rec_run(15, 0, 0, 1'b0, 1 << ADDR_W);
    ignored_start(1'b1, 0, "R8 all slots used ignored");

    for (int p = 0; p < PHRASES; p++)
      play_run(p, p % 4, (p == 1) ? 5 : ((p == 3) ? 10 : -1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule